// File: doc/BRIEF.md
# Scanline Interrupt Counter with A12 Edge Filter

This block produces a per-scanline interrupt for a video cartridge controller. It watches the CPU bus clock (M2) and bit 12 of the picture processor's address bus (A12). A rendered line fetches background data with A12 low for a long stretch and then sprite data with A12 high. A filter turns that pattern into one scanline event per line. Each event steps an 8-bit programmable counter, and when the counter runs out the block pulls an active-low interrupt line.

Software sets the block up through a four-register write port. The registers are a reload value, a restart strobe, an interrupt disable that also acknowledges, and an interrupt enable. The restart strobe has two timing-dependent effects. It lowers the filter threshold for the first line that follows. It also decides whether the first count runs one line long, based on how recently A12 was last high.

All logic runs on a fast system clock. M2 is sampled as a level, and each M2 falling edge becomes a one-cycle clock enable. Each M2 cycle is judged by the A12 value seen at its falling edge.

Top module: `scanline_irq`

## Requirements
- R1: A scanline event is recognised when A12 (`ppu_addr_hi[2]`) is high at an M2 falling edge and the preceding run of consecutive A12-low M2 cycles is at least 17 long. A shorter run gives no event. The low-run count is 0 after reset.
- R2: After an event, `irq_n` can fall only at the next M2 falling edge (one whole M2 cycle after the A12-high cycle), whatever A12 does in that cycle. It never falls at the A12-high cycle's own edge.
- R3: Further A12-high M2 cycles after the first one add no event. Only the first high cycle after a qualifying low run counts.
- R4: `ppu_addr_hi[1:0]` (A11, A10) has no effect on event recognition.
- R5: After a restart write (`wr_sel`=1, `wr_data[0]`=0) made when at least 4 low M2 cycles have completed since A12 was last high, the first event needs only 13 low cycles in total, counting those before and after the write. With fewer than 4 before the write, 17 are still needed. The lowered threshold ends at the next A12-high cycle.
- R6: `wr_sel`=0 stores the reload value R, which is 0xFF after reset. The counter is 0 after reset. On an event with no restart pending, a zero counter loads R and a non-zero counter decrements. When the result is 0 and the interrupt is enabled, `irq_n` goes low. This gives one interrupt every R+1 events.
- R7: A restart write made when 16 or more low M2 cycles have completed since A12 was last high makes the next event load R+1. The first interrupt then comes on event R+2.
- R8: A restart write made when fewer than 16 low M2 cycles have completed since A12 was last high makes the next event load R. The first interrupt then comes on event R+1; with R=0 it comes on the first event.
- R9: A write to `wr_sel`=1 with `wr_data[0]`=1 has no effect on the counter or the filter.
- R10: A write to `wr_sel`=2 clears the enable and raises `irq_n` on the next clock. If it lands in the same clock as an interrupt-raising event, the write wins.
- R11: A write to `wr_sel`=3 sets the enable only. It neither raises a pending interrupt nor clears an asserted one. An asserted interrupt stays until a `wr_sel`=2 write.
- R12: After reset `irq_n` is high and the interrupt is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than M2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| m2 | input | 1 | CPU bus clock level, synchronous to clk |
| ppu_addr_hi | input | 3 | Picture address bits {A12, A11, A10} |
| wr_en | input | 1 | One-clock write strobe |
| wr_sel | input | 2 | Register select: 0 reload, 1 restart, 2 disable/ack, 3 enable |
| wr_data | input | 8 | Write data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
An interrupt-raising scanline event and a disable write can land in the same system clock. The bench provokes this by issuing the disable write on the exact clock where M2 falls one cycle after a qualifying A12-high cycle. The line must stay high there, and a later enable plus a new event must still raise it, which shows the counter stepped normally. A restart write can also lower the filter threshold and choose the plus-one load at once. The bench judges both effects together by placing the write at 15 and at 16 completed low cycles with a reload of 0.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned LOW_FULL  = 17;
  localparam int unsigned LOW_SHORT = 13;
  localparam int unsigned PRE_MIN   = 4;
  localparam int unsigned NEAR_WIN  = 16;

  typedef enum logic [1:0] {
    SEL_RELOAD  = 2'd0,
    SEL_RESTART = 2'd1,
    SEL_IRQ_OFF = 2'd2,
    SEL_IRQ_ON  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/m2_fall_detect.sv
module m2_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic m2,
  output logic fall_ce
);
  logic m2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m2_q <= 1'b0;
    else        m2_q <= m2;
  end

  assign fall_ce = m2_q & ~m2;
endmodule

// File: rtl/a12_line_filter.sv
module a12_line_filter #(
  parameter int unsigned LOW_FULL  = 17,
  parameter int unsigned LOW_SHORT = 13,
  parameter int unsigned PRE_MIN   = 4,
  parameter int unsigned NEAR_WIN  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_ce,
  input  logic a12,
  input  logic restart_wr,
  output logic evt_q,
  output logic evt_fire,
  output logic near_high
);
  localparam int unsigned LOW_W = $clog2(LOW_FULL + 1);
  localparam logic [LOW_W-1:0] FULL_V  = LOW_W'(LOW_FULL);
  localparam logic [LOW_W-1:0] SHORT_V = LOW_W'(LOW_SHORT);
  localparam logic [LOW_W-1:0] PRE_V   = LOW_W'(PRE_MIN);
  localparam logic [LOW_W-1:0] NEAR_V  = LOW_W'(NEAR_WIN);

  logic [LOW_W-1:0] low_q, low_d, thr;
  logic             short_q, short_d;
  logic             evt_d, hit;

  always_comb begin
    thr = short_q ? SHORT_V : FULL_V;
    hit = a12 && (low_q >= thr);

    low_d = low_q;
    if (fall_ce) begin
      if (a12)                 low_d = '0;
      else if (low_q != FULL_V) low_d = low_q + 1'b1;
    end

    short_d = short_q;
    if (restart_wr)          short_d = (low_q >= PRE_V);
    else if (fall_ce && a12) short_d = 1'b0;

    evt_d = fall_ce ? hit : evt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      short_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      low_q   <= low_d;
      short_q <= short_d;
      evt_q   <= evt_d;
    end
  end

  assign evt_fire  = fall_ce & evt_q;
  assign near_high = (low_q < NEAR_V);
endmodule

// File: rtl/line_down_counter.sv
module line_down_counter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_fire,
  input  logic              restart_wr,
  input  logic              near_high,
  input  logic              reload_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              zero_hit
);
  localparam int unsigned CNT_W = DATA_W + 1;

  logic [DATA_W-1:0] reload_q, reload_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, load_val;
  logic              pend_q, pend_d, plain_q, plain_d;

  always_comb begin
    reload_d = reload_wr ? wr_data : reload_q;

    if (pend_q && !plain_q) load_val = CNT_W'(reload_q) + CNT_W'(1);
    else                    load_val = CNT_W'(reload_q);

    cnt_d = cnt_q;
    if (evt_fire) begin
      if (pend_q || (cnt_q == '0)) cnt_d = load_val;
      else                         cnt_d = cnt_q - 1'b1;
    end

    pend_d = pend_q;
    if (restart_wr)    pend_d = 1'b1;
    else if (evt_fire) pend_d = 1'b0;

    plain_d = restart_wr ? near_high : plain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      plain_q  <= 1'b0;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
      pend_q   <= pend_d;
      plain_q  <= plain_d;
    end
  end

  assign zero_hit = evt_fire && (cnt_d == '0);
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_hit,
  input  logic off_wr,
  input  logic on_wr,
  output logic irq_n
);
  logic en_q, en_d, irq_q, irq_d;

  always_comb begin
    en_d = en_q;
    if (off_wr)     en_d = 1'b0;
    else if (on_wr) en_d = 1'b1;

    irq_d = irq_q;
    if (off_wr)                irq_d = 1'b0;
    else if (zero_hit && en_q) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

  assign irq_n = ~irq_q;
endmodule

// File: rtl/scanline_irq.sv
module scanline_irq
  import scanline_irq_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m2,
  input  logic [2:0]    ppu_addr_hi,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          irq_n
);
  logic rst_s1_q, rst_sync_n;
  logic fall_ce, a12, evt_q, evt_fire, near_high, zero_hit;
  logic restart_wr, reload_wr, off_wr, on_wr;
  logic unused_side_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  assign a12              = ppu_addr_hi[2];
  assign unused_side_bits = ^ppu_addr_hi[1:0];

  assign reload_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_RELOAD);
  assign restart_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_RESTART) && !wr_data[0];
  assign off_wr     = wr_en && (reg_sel_e'(wr_sel) == SEL_IRQ_OFF);
  assign on_wr      = wr_en && (reg_sel_e'(wr_sel) == SEL_IRQ_ON);

  m2_fall_detect i_fall (
    .clk(clk), .rst_n(rst_sync_n), .m2(m2), .fall_ce(fall_ce)
  );

  a12_line_filter #(
    .LOW_FULL(LOW_FULL), .LOW_SHORT(LOW_SHORT),
    .PRE_MIN(PRE_MIN), .NEAR_WIN(NEAR_WIN)
  ) i_filt (
    .clk(clk), .rst_n(rst_sync_n), .fall_ce(fall_ce), .a12(a12),
    .restart_wr(restart_wr), .evt_q(evt_q), .evt_fire(evt_fire),
    .near_high(near_high)
  );

  line_down_counter #(.DATA_W(DW)) i_cnt (
    .clk(clk), .rst_n(rst_sync_n), .evt_fire(evt_fire),
    .restart_wr(restart_wr), .near_high(near_high),
    .reload_wr(reload_wr), .wr_data(wr_data), .zero_hit(zero_hit)
  );

  irq_gate i_irq (
    .clk(clk), .rst_n(rst_sync_n), .zero_hit(zero_hit),
    .off_wr(off_wr), .on_wr(on_wr), .irq_n(irq_n)
  );
endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fall_ce,
  input logic       a12,
  input logic       evt_q,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       irq_n
);
  AST_IRQ_FALLS_AT_M2_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(fall_ce)); // R2

  AST_EVENT_FROM_A12_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> ($past(a12) && $past(fall_ce))); // R1

  AST_ONE_EVENT_PER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && fall_ce) |=> !evt_q); // R3

  AST_DISABLE_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=> irq_n); // R10

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !(wr_en && wr_sel == 2'd2)) |=> !irq_n); // R11
endmodule

bind scanline_irq scanline_irq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .fall_ce(fall_ce), .a12(a12), .evt_q(evt_q),
  .wr_en(wr_en), .wr_sel(wr_sel), .irq_n(irq_n)
);

// File: tb/test_scanline_irq.sv
module test_scanline_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m2 = 1'b0;
  logic [2:0] ppu_addr_hi = 3'b000;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       irq_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // vector: {low run [7:0], A11/A10 toggle pattern [1:0], event expected}
  localparam logic [10:0] VEC [6] = '{
    {8'd16, 2'b00, 1'b0},
    {8'd17, 2'b00, 1'b1},
    {8'd25, 2'b00, 1'b1},
    {8'd4,  2'b11, 1'b0},
    {8'd17, 2'b11, 1'b1},
    {8'd16, 2'b10, 1'b0}
  };

  scanline_irq i_scanline_irq (
    .clk(clk), .rst_n(rst_n), .m2(m2), .ppu_addr_hi(ppu_addr_hi),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_n(irq_n)
  );

  always #5 clk = ~clk;

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check_irq(input logic exp_n, input string tag);
    checks++;
    if (irq_n !== exp_n) begin
      fails++;
      $display("FAIL %s irq_n=%b expected %b", tag, irq_n, exp_n);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; m2 = 1'b0; ppu_addr_hi = 3'b000; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cyc(input logic hi, input logic [1:0] side);
    @(negedge clk); m2 = 1'b1; ppu_addr_hi = {hi, side};
    @(negedge clk);
    @(negedge clk); m2 = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic cyc_wr(input logic hi, input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk); m2 = 1'b1; ppu_addr_hi = {hi, 2'b00};
    @(negedge clk);
    @(negedge clk); m2 = 1'b0; wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic lows(input int n, input logic [1:0] side);
    for (int i = 0; i < n; i++) cyc(1'b0, (i % 2 == 1) ? side : 2'b00);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic line_evt();
    lows(17, 2'b00);
    cyc(1'b1, 2'b00);
    cyc(1'b0, 2'b00);
  endtask

  task automatic ack();
    wr(2'd2, 8'd0);
    wr(2'd3, 8'd0);
  endtask

  initial begin
    // R1/R2/R4: vector walk with reload 0 so every event interrupts
    for (int v = 0; v < 6; v++) begin
      do_reset();
      wr(2'd0, 8'd0);
      wr(2'd3, 8'd0);
      lows(int'(VEC[v][10:3]), VEC[v][2:1]);
      cyc(1'b1, VEC[v][2:1]);
      check_irq(1'b1, "R2 vector no irq at high edge");
      cyc(1'b0, VEC[v][2:1]);
      check_irq(!VEC[v][0], "R1 R4 vector threshold");
    end

    // R12 reset state, then default reload 0xFF gives 256-event period
    do_reset();
    check_irq(1'b1, "R12 after reset");
    wr(2'd3, 8'd0);
    for (int k = 0; k < 255; k++) line_evt();
    check_irq(1'b1, "R12 default reload 255 events");
    line_evt();
    check_irq(1'b0, "R12 default reload 256th event");

    // R2/R3: second high cycle fires irq, extra highs add no event
    do_reset();
    wr(2'd0, 8'd0); wr(2'd3, 8'd0);
    lows(17, 2'b00);
    cyc(1'b1, 2'b00);
    check_irq(1'b1, "R2 not at own edge");
    cyc(1'b1, 2'b00);
    check_irq(1'b0, "R2 next edge with A12 high");
    ack();
    cyc(1'b1, 2'b00); cyc(1'b1, 2'b00); cyc(1'b0, 2'b00);
    check_irq(1'b1, "R3 extra highs ignored");

    // R6: reload 2, period 3
    do_reset();
    wr(2'd0, 8'd2); wr(2'd3, 8'd0);
    line_evt(); line_evt();
    check_irq(1'b1, "R6 after 2 events");
    line_evt();
    check_irq(1'b0, "R6 3rd event");
    ack();
    line_evt(); line_evt();
    check_irq(1'b1, "R6 after 5 events");
    line_evt();
    check_irq(1'b0, "R6 6th event");

    // R7: far restart, reload 2 -> first irq on event 4
    do_reset();
    wr(2'd0, 8'd2); wr(2'd3, 8'd0);
    lows(20, 2'b00);
    wr(2'd1, 8'd0);
    line_evt(); line_evt(); line_evt();
    check_irq(1'b1, "R7 after 3 events");
    line_evt();
    check_irq(1'b0, "R7 4th event");

    // R8/R7 window boundary with reload 0
    do_reset();
    wr(2'd0, 8'd0); wr(2'd3, 8'd0);
    lows(15, 2'b00);
    wr(2'd1, 8'd0);
    cyc(1'b1, 2'b00); cyc(1'b0, 2'b00);
    check_irq(1'b0, "R8 restart at 15 lows plain");
    do_reset();
    wr(2'd0, 8'd0); wr(2'd3, 8'd0);
    lows(16, 2'b00);
    wr(2'd1, 8'd0);
    cyc(1'b1, 2'b00); cyc(1'b0, 2'b00);
    check_irq(1'b1, "R7 restart at 16 lows plus one");
    line_evt();
    check_irq(1'b0, "R7 second event");

    // R5: short threshold after restart
    do_reset();
    wr(2'd0, 8'd0); wr(2'd3, 8'd0);
    lows(5, 2'b00); wr(2'd1, 8'd0); lows(8, 2'b00);
    cyc(1'b1, 2'b00); cyc(1'b0, 2'b00);
    check_irq(1'b0, "R5 5+8 lows");
    ack();
    lows(15, 2'b00); cyc(1'b1, 2'b00); cyc(1'b0, 2'b00);
    check_irq(1'b1, "R5 threshold back to 17");
    lows(16, 2'b00); cyc(1'b1, 2'b00); cyc(1'b0, 2'b00);
    check_irq(1'b0, "R5 17 lows after consume");
    do_reset();
    wr(2'd0, 8'd0); wr(2'd3, 8'd0);
    lows(5, 2'b00); wr(2'd1, 8'd0); lows(7, 2'b00);
    cyc(1'b1, 2'b00); cyc(1'b0, 2'b00);
    check_irq(1'b1, "R5 5+7 lows");
    do_reset();
    wr(2'd0, 8'd0); wr(2'd3, 8'd0);
    lows(3, 2'b00); wr(2'd1, 8'd0); lows(10, 2'b00);
    cyc(1'b1, 2'b00); cyc(1'b0, 2'b00);
    check_irq(1'b1, "R5 3 before write");

    // R9: mode bit set is ignored
    do_reset();
    wr(2'd0, 8'd0); wr(2'd3, 8'd0);
    lows(20, 2'b00); wr(2'd1, 8'h01);
    cyc(1'b1, 2'b00); cyc(1'b0, 2'b00);
    check_irq(1'b0, "R9 bit0 set ignored");

    // R10: disable in the same clock as the raising event
    do_reset();
    wr(2'd0, 8'd0); wr(2'd3, 8'd0);
    lows(17, 2'b00); cyc(1'b1, 2'b00);
    cyc_wr(1'b0, 2'd2, 8'd0);
    check_irq(1'b1, "R10 disable wins same clock");
    wr(2'd3, 8'd0);
    line_evt();
    check_irq(1'b0, "R10 counter still stepped");
    wr(2'd2, 8'd0);
    check_irq(1'b1, "R10 disable acknowledges");

    // R11/R12: enable neither raises nor clears
    do_reset();
    wr(2'd0, 8'd0);
    line_evt();
    check_irq(1'b1, "R12 disabled after reset");
    wr(2'd3, 8'd0);
    check_irq(1'b1, "R11 enable does not raise");
    line_evt();
    check_irq(1'b0, "R11 enabled event");
    wr(2'd3, 8'd0);
    check_irq(1'b0, "R11 enable does not clear");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule